// File: doc/BRIEF.md
# Thread Block Dispatch Resource Allocator

This block sits between an upstream work distributor and one compute unit. It decides whether a thread-block launch request can be placed on the unit, reserves what the block needs, and returns those resources as the block's warps drain. A request names a block id chosen by the distributor, a shared-memory size in allocation units, a warp count, a register count per warp and a barrier count. The request is taken only when every pool can cover it at once. Otherwise `req_ready` stays low and the distributor keeps presenting it.

An accepted block's warps are dealt one by one across the sub-partitions in round-robin order. Each sub-partition owns a set of warp slots and a register pool. A warp keeps its sub-partition and slot until it is released. The execution side reports when a warp's threads have finished and exposes, per slot, how many issued instructions are still in flight. The slot and its registers return only when that count is zero. When the last warp of a block is released, the block's shared memory, barriers and block id are freed, and a single-cycle notice carrying the id goes back upstream.

The reset is asynchronous and active low. Its release is expected to be synchronous to `clk`.

Top module: `tbd_alloc`

## Requirements
- R1: `req_ready` is high in a cycle exactly when all of the following hold: the requested block id is not resident, the warp count is at least one, free shared-memory units and free barriers cover the request, and every sub-partition has enough free slots and free registers for its share of the warps. While `req_ready` is low, nothing is booked.
- R2: On acceptance, the shared-memory units and barriers are deducted from their pools. They are returned when the block completes.
- R3: Warp k of an accepted block goes to sub-partition (P + k) mod NUM_SP, where P is the round-robin pointer (0 after reset). Within a sub-partition, warps take the lowest-numbered free slots. P then advances by the warp count mod NUM_SP and carries over to later blocks.
- R4: If any sub-partition that must receive a warp has no free slot for it, the whole request is refused, even when other sub-partitions have room. No sub-partition is skipped.
- R5: Each sub-partition's register pool must hold its warp share times the per-warp register count. Each released warp returns its per-warp count to its own sub-partition.
- R6: A finish report (`wf_valid` with `wf_sp`, `wf_slot`, and `wf_blk` equal to the owning block) marks a resident warp finished. Its slot and registers are released at the first clock edge at which the flag is set and the slot's outstanding count is zero. That count is the PW-bit field of `pend_cnt` at index `wf_sp*SLOTS + wf_slot`. At most one warp is released per cycle, lowest index first.
- R7: After the edge that releases a block's last warp, `done_valid` is high for exactly one cycle, with `done_blk` holding that block id.
- R8: A slot, registers, shared memory, barriers or a block id being released in a cycle count as available to an admission decided in that same cycle.
- R9: After reset, all pools are full, no block is resident, the pointer is 0 and `done_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Request can be admitted this cycle |
| req_blk | input | BW | Block id of the request |
| req_smem | input | SMW | Shared memory in allocation units |
| req_warps | input | WW | Warps in the block |
| req_regs | input | RW | Registers needed per warp |
| req_bar | input | BRW | Barriers needed |
| wf_valid | input | 1 | Warp-finish report |
| wf_blk | input | BW | Block owning the finished warp |
| wf_sp | input | SPW | Sub-partition of the finished warp |
| wf_slot | input | SLW | Slot of the finished warp |
| pend_cnt | input | NSLOT*PW | Per-slot count of in-flight instructions |
| done_valid | output | 1 | Block completion notice |
| done_blk | output | BW | Id of the completed block |

## Verification
The checker assumes that every finish report targets a slot that currently holds a warp. It also assumes the outstanding counts are meaningful only for resident warps. The stimulus keeps to this by reporting only slots it has worked out from the round-robin rule. Apart from the case that tests a held release, it leaves all counts at zero. Requests the bench expects to be refused are driven with the same block id across cycles, and the bench never finishes a warp of a block it has not had admitted.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  // Number of warps of a block that land on sub-partition sp when dealing
  // starts at sub-partition ptr.
  function automatic int unsigned rr_share(input int unsigned sp, input int unsigned ptr,
                                           input int unsigned warps, input int unsigned nsp);
    int unsigned off;
    off = (sp + nsp - ptr) % nsp;
    return warps / nsp + ((off < warps % nsp) ? 32'd1 : 32'd0);
  endfunction
endpackage

// File: rtl/tbd_slot_pick.sv
module tbd_slot_pick #(
  parameter int SLOTS = 8,
  parameter int NW    = 6
) (
  input  logic [SLOTS-1:0] free_mask,
  input  logic [NW-1:0]    need,
  output logic [SLOTS-1:0] grant
);
  int unsigned taken;

  always_comb begin
    taken = 0;
    grant = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (free_mask[i] && (taken < 32'(need))) begin
        grant[i] = 1'b1;
        taken    = taken + 1;
      end
    end
  end
endmodule

// File: rtl/tbd_sp_fit.sv
module tbd_sp_fit #(
  parameter int SLOTS = 8,
  parameter int NW    = 6,
  parameter int RW    = 15
) (
  input  logic [SLOTS-1:0]   free_mask,
  input  logic [NW-1:0]      need,
  input  logic [RW-1:0]      regs_free,
  input  logic [RW-1:0]      regs_per_warp,
  output logic               fit,
  output logic [RW+NW-1:0]   cost,
  output logic [SLOTS-1:0]   grant
);
  localparam int CW = RW + NW;

  assign cost = CW'(need) * CW'(regs_per_warp);
  assign fit  = (32'($countones(free_mask)) >= 32'(need)) && (cost <= CW'(regs_free));

  tbd_slot_pick #(.SLOTS(SLOTS), .NW(NW)) u_pick (
    .free_mask (free_mask),
    .need      (need),
    .grant     (grant)
  );
endmodule

// File: rtl/tbd_rel_pick.sv
module tbd_rel_pick #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic [N-1:0]  rdy,
  output logic          vld,
  output logic [IW-1:0] idx
);
  always_comb begin
    vld = |rdy;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rdy[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tbd_alloc.sv
module tbd_alloc #(
  parameter int NUM_SP     = 4,
  parameter int SLOTS      = 8,
  parameter int SMEM_UNITS = 256,
  parameter int REGS_SP    = 16384,
  parameter int NBAR       = 16,
  parameter int NBLK       = 16,
  parameter int PW         = 4,
  localparam int NSLOT = NUM_SP * SLOTS,
  localparam int SPW   = $clog2(NUM_SP),
  localparam int SLW   = $clog2(SLOTS),
  localparam int IW    = $clog2(NSLOT),
  localparam int BW    = $clog2(NBLK),
  localparam int WW    = $clog2(NSLOT + 1),
  localparam int SMW   = $clog2(SMEM_UNITS + 1),
  localparam int RW    = $clog2(REGS_SP + 1),
  localparam int BRW   = $clog2(NBAR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BW-1:0]     req_blk,
  input  logic [SMW-1:0]    req_smem,
  input  logic [WW-1:0]     req_warps,
  input  logic [RW-1:0]     req_regs,
  input  logic [BRW-1:0]    req_bar,
  input  logic              wf_valid,
  input  logic [BW-1:0]     wf_blk,
  input  logic [SPW-1:0]    wf_sp,
  input  logic [SLW-1:0]    wf_slot,
  input  logic [NSLOT*PW-1:0] pend_cnt,
  output logic              done_valid,
  output logic [BW-1:0]     done_blk
);
  // Architectural state
  logic [NSLOT-1:0] slot_busy, slot_busy_n, slot_fin, slot_fin_n;
  logic [BW-1:0]    slot_owner [NSLOT];
  logic [BW-1:0]    slot_owner_n [NSLOT];
  logic [RW-1:0]    sp_regs [NUM_SP];
  logic [RW-1:0]    sp_regs_n [NUM_SP];
  logic [SMW-1:0]   smem_free, smem_free_n;
  logic [BRW-1:0]   bar_free, bar_free_n;
  logic [NBLK-1:0]  blk_busy, blk_busy_n;
  logic [WW-1:0]    blk_left [NBLK];
  logic [WW-1:0]    blk_left_n [NBLK];
  logic [SMW-1:0]   blk_smem [NBLK];
  logic [SMW-1:0]   blk_smem_n [NBLK];
  logic [BRW-1:0]   blk_bar [NBLK];
  logic [BRW-1:0]   blk_bar_n [NBLK];
  logic [RW-1:0]    blk_rpw [NBLK];
  logic [RW-1:0]    blk_rpw_n [NBLK];
  logic [SPW-1:0]   rr_ptr, rr_ptr_n;
  logic             done_valid_n;
  logic [BW-1:0]    done_blk_n;

  // Release path
  logic [NSLOT-1:0] rel_rdy, rel_oh;
  logic             rel_vld, rel_last;
  logic [IW-1:0]    rel_idx;
  logic [SPW-1:0]   rel_sp;
  logic [BW-1:0]    rel_own;

  // Admission path
  logic [NSLOT-1:0] free_eff, grant_all;
  logic [WW-1:0]    need [NUM_SP];
  logic [RW-1:0]    regs_eff [NUM_SP];
  logic [RW+WW-1:0] sp_cost [NUM_SP];
  logic [NUM_SP-1:0] sp_fit;
  logic [SMW-1:0]   smem_eff;
  logic [BRW-1:0]   bar_eff;
  logic             blk_avail, accept, state_en;
  logic [IW-1:0]    wf_idx;

  for (genvar i = 0; i < NSLOT; i++) begin : g_rdy
    assign rel_rdy[i] = slot_busy[i] & slot_fin[i] & (pend_cnt[i*PW +: PW] == '0);
  end

  tbd_rel_pick #(.N(NSLOT), .IW(IW)) u_rel (.rdy(rel_rdy), .vld(rel_vld), .idx(rel_idx));

  assign rel_oh   = rel_vld ? (NSLOT'(1) << rel_idx) : '0;
  assign rel_sp   = SPW'(32'(rel_idx) / SLOTS);
  assign rel_own  = slot_owner[rel_idx];
  assign rel_last = rel_vld && (blk_left[rel_own] == WW'(1));
  assign free_eff = ~slot_busy | rel_oh;
  assign smem_eff = smem_free + (rel_last ? blk_smem[rel_own] : '0);
  assign bar_eff  = bar_free + (rel_last ? blk_bar[rel_own] : '0);
  assign blk_avail = !blk_busy[req_blk] || (rel_last && (rel_own == req_blk));

  for (genvar s = 0; s < NUM_SP; s++) begin : g_sp
    assign need[s] = WW'(tbd_pkg::rr_share(s, 32'(rr_ptr), 32'(req_warps), NUM_SP));
    assign regs_eff[s] = sp_regs[s] +
                         ((rel_vld && (rel_sp == SPW'(s))) ? blk_rpw[rel_own] : '0);
    tbd_sp_fit #(.SLOTS(SLOTS), .NW(WW), .RW(RW)) u_fit (
      .free_mask     (free_eff[s*SLOTS +: SLOTS]),
      .need          (need[s]),
      .regs_free     (regs_eff[s]),
      .regs_per_warp (req_regs),
      .fit           (sp_fit[s]),
      .cost          (sp_cost[s]),
      .grant         (grant_all[s*SLOTS +: SLOTS])
    );
  end

  assign req_ready = (&sp_fit) && blk_avail && (req_warps != '0) &&
                     (smem_eff >= req_smem) && (bar_eff >= req_bar);
  assign accept    = req_valid && req_ready;
  assign wf_idx    = IW'(32'(wf_sp) * SLOTS + 32'(wf_slot));
  assign state_en  = rel_vld || wf_valid || accept;

  // Next state: release first, then finish marking, then admission.
  always_comb begin
    slot_busy_n  = slot_busy;
    slot_fin_n   = slot_fin;
    slot_owner_n = slot_owner;
    sp_regs_n    = sp_regs;
    smem_free_n  = smem_free;
    bar_free_n   = bar_free;
    blk_busy_n   = blk_busy;
    blk_left_n   = blk_left;
    blk_smem_n   = blk_smem;
    blk_bar_n    = blk_bar;
    blk_rpw_n    = blk_rpw;
    rr_ptr_n     = rr_ptr;
    done_valid_n = 1'b0;
    done_blk_n   = done_blk;

    if (rel_vld) begin
      slot_busy_n[rel_idx] = 1'b0;
      slot_fin_n[rel_idx]  = 1'b0;
      sp_regs_n[rel_sp]    = sp_regs[rel_sp] + blk_rpw[rel_own];
      blk_left_n[rel_own]  = blk_left[rel_own] - WW'(1);
      if (rel_last) begin
        blk_busy_n[rel_own] = 1'b0;
        smem_free_n  = smem_eff;
        bar_free_n   = bar_eff;
        done_valid_n = 1'b1;
        done_blk_n   = rel_own;
      end
    end

    if (wf_valid && slot_busy[wf_idx] && !rel_oh[wf_idx] && (slot_owner[wf_idx] == wf_blk))
      slot_fin_n[wf_idx] = 1'b1;

    if (accept) begin
      smem_free_n         = smem_free_n - req_smem;
      bar_free_n          = bar_free_n - req_bar;
      blk_busy_n[req_blk] = 1'b1;
      blk_left_n[req_blk] = req_warps;
      blk_smem_n[req_blk] = req_smem;
      blk_bar_n[req_blk]  = req_bar;
      blk_rpw_n[req_blk]  = req_regs;
      rr_ptr_n = SPW'((32'(rr_ptr) + 32'(req_warps)) % NUM_SP);
      for (int s = 0; s < NUM_SP; s++) sp_regs_n[s] = sp_regs_n[s] - RW'(sp_cost[s]);
      for (int i = 0; i < NSLOT; i++) begin
        if (grant_all[i]) begin
          slot_busy_n[i]  = 1'b1;
          slot_fin_n[i]   = 1'b0;
          slot_owner_n[i] = req_blk;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_busy  <= '0;
      slot_fin   <= '0;
      smem_free  <= SMW'(SMEM_UNITS);
      bar_free   <= BRW'(NBAR);
      blk_busy   <= '0;
      rr_ptr     <= '0;
      done_valid <= 1'b0;
      done_blk   <= '0;
      for (int i = 0; i < NSLOT; i++) slot_owner[i] <= '0;
      for (int s = 0; s < NUM_SP; s++) sp_regs[s] <= RW'(REGS_SP);
      for (int b = 0; b < NBLK; b++) begin
        blk_left[b] <= '0;
        blk_smem[b] <= '0;
        blk_bar[b]  <= '0;
        blk_rpw[b]  <= '0;
      end
    end else begin
      done_valid <= done_valid_n;
      done_blk   <= done_blk_n;
      if (state_en) begin
        slot_busy  <= slot_busy_n;
        slot_fin   <= slot_fin_n;
        slot_owner <= slot_owner_n;
        sp_regs    <= sp_regs_n;
        smem_free  <= smem_free_n;
        bar_free   <= bar_free_n;
        blk_busy   <= blk_busy_n;
        blk_left   <= blk_left_n;
        blk_smem   <= blk_smem_n;
        blk_bar    <= blk_bar_n;
        blk_rpw    <= blk_rpw_n;
        rr_ptr     <= rr_ptr_n;
      end
    end
  end
endmodule

// File: rtl/tbd_alloc_chk.sv
module tbd_alloc_chk #(
  parameter int NUM_SP     = 4,
  parameter int SLOTS      = 8,
  parameter int SMEM_UNITS = 256,
  parameter int NBAR       = 16,
  parameter int PW         = 4,
  parameter int SPW        = 2,
  parameter int SLW        = 3,
  parameter int WW         = 6,
  parameter int SMW        = 9,
  parameter int BRW        = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_ready,
  input logic [WW-1:0]              req_warps,
  input logic                       wf_valid,
  input logic [SPW-1:0]             wf_sp,
  input logic [SLW-1:0]             wf_slot,
  input logic [NUM_SP*SLOTS*PW-1:0] pend_cnt,
  input logic                       done_valid,
  input logic                       accept,
  input logic                       rel_vld,
  input logic [NUM_SP*SLOTS-1:0]    rel_oh,
  input logic [NUM_SP*SLOTS-1:0]    grant_all,
  input logic [NUM_SP*SLOTS-1:0]    slot_busy,
  input logic [SMW-1:0]             smem_free,
  input logic [BRW-1:0]             bar_free
);
  localparam int NSLOT = NUM_SP * SLOTS;

  AST_READY_NEEDS_WARPS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (req_warps != '0)); // R1
  AST_SMEM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    32'(smem_free) <= SMEM_UNITS); // R2
  AST_BAR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    32'(bar_free) <= NBAR); // R2
  AST_GRANT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (32'($countones(grant_all)) == 32'(req_warps))); // R3
  AST_GRANT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ((grant_all & slot_busy & ~rel_oh) == '0)); // R8
  AST_WF_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wf_valid |-> slot_busy[32'(wf_sp) * SLOTS + 32'(wf_slot)]); // R6
  AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(rel_vld)); // R7

  for (genvar i = 0; i < NSLOT; i++) begin : g_hold
    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_busy[i] && (pend_cnt[i*PW +: PW] != '0)) |=> slot_busy[i]); // R6
  end
endmodule

bind tbd_alloc tbd_alloc_chk #(
  .NUM_SP(NUM_SP), .SLOTS(SLOTS), .SMEM_UNITS(SMEM_UNITS), .NBAR(NBAR), .PW(PW),
  .SPW(SPW), .SLW(SLW), .WW(WW), .SMW(SMW), .BRW(BRW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_warps(req_warps),
  .wf_valid(wf_valid), .wf_sp(wf_sp), .wf_slot(wf_slot), .pend_cnt(pend_cnt),
  .done_valid(done_valid), .accept(accept), .rel_vld(rel_vld), .rel_oh(rel_oh),
  .grant_all(grant_all), .slot_busy(slot_busy), .smem_free(smem_free), .bar_free(bar_free)
);

// File: tb/tbd_alloc_tb.sv
module tbd_alloc_tb_top;
  localparam int BW = 4, SMW = 9, WW = 6, RW = 15, BRW = 5, SPW = 2, SLW = 3, PW = 4;
  localparam int NSLOT = 32;

  logic clk, rst_n, req_valid, req_ready, wf_valid, done_valid;
  logic [BW-1:0]  req_blk, wf_blk, done_blk;
  logic [SMW-1:0] req_smem;
  logic [WW-1:0]  req_warps;
  logic [RW-1:0]  req_regs;
  logic [BRW-1:0] req_bar;
  logic [SPW-1:0] wf_sp;
  logic [SLW-1:0] wf_slot;
  logic [NSLOT*PW-1:0] pend_cnt;

  int checks = 0, errors = 0;
  bit finished = 0;

  tbd_alloc dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_blk(req_blk), .req_smem(req_smem), .req_warps(req_warps), .req_regs(req_regs),
    .req_bar(req_bar), .wf_valid(wf_valid), .wf_blk(wf_blk), .wf_sp(wf_sp),
    .wf_slot(wf_slot), .pend_cnt(pend_cnt), .done_valid(done_valid), .done_blk(done_blk)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // blk, smem, warps, regs/warp, barriers, expected ready
  localparam int VEC [8][6] = '{
    '{0, 100, 4, 1000,  2, 1},  // R1 fits; R3 sp0..3 slot0
    '{1, 200, 1,    0,  0, 0},  // R1 smem short
    '{1, 150, 3, 2000, 14, 1},  // R3 sp0..2 slot1, ptr -> 3
    '{2,   6, 1,    0,  1, 0},  // R2 barriers exhausted
    '{2,   6, 1, 14000, 0, 1},  // R5 sp3 has 15384 left, slot1
    '{3,   0, 1, 14000, 0, 0},  // R5 sp0 has only 13384
    '{0,   0, 1,    0,  0, 0},  // R1 block id resident
    '{3,   0, 2, 5000,  0, 1}   // R3 sp0 slot2, sp1 slot2
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_req(input int blk, input int smem, input int warps, input int regs,
                         input int bar, input bit vld);
    req_blk = BW'(blk); req_smem = SMW'(smem); req_warps = WW'(warps);
    req_regs = RW'(regs); req_bar = BRW'(bar); req_valid = vld;
  endtask

  task automatic finish(input int sp, input int slot, input int blk);
    @(negedge clk);
    wf_valid = 1'b1; wf_sp = SPW'(sp); wf_slot = SLW'(slot); wf_blk = BW'(blk);
    @(negedge clk);
    wf_valid = 1'b0;
  endtask

  task automatic expect_done(input int blk, input string tag);
    chk({tag, " done low before release"}, int'(done_valid), 0);
    @(negedge clk);
    chk({tag, " done pulse"}, int'(done_valid), 1);
    chk({tag, " done id"}, int'(done_blk), blk);
    @(negedge clk);
    chk({tag, " done single cycle"}, int'(done_valid), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; wf_valid = 1'b0; pend_cnt = '0;
    set_req(0, 0, 0, 0, 0, 0);
    wf_sp = '0; wf_slot = '0; wf_blk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9: watchdog actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9 reset state: idle notice, full pools accept the largest request
    chk("R9 done low after reset", int'(done_valid), 0);
    set_req(15, 256, 32, 512, 16, 0);
    #1 chk("R9 full pools after reset", int'(req_ready), 1);

    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      set_req(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 1'b1);
      #1 chk($sformatf("R1 vector %0d ready", v), int'(req_ready), VEC[v][5]);
    end
    @(negedge clk);
    req_valid = 1'b0;

    // R2 shared memory still held by block 2
    set_req(4, 7, 1, 0, 0, 0);
    #1 chk("R2 smem not yet returned", int'(req_ready), 0);

    // R3/R7 block 2 lives on sp3 slot1
    finish(3, 1, 2);
    expect_done(2, "R7 block2");

    // R2 shared memory of block 2 returned
    set_req(4, 6, 1, 0, 0, 0);
    #1 chk("R2 smem returned", int'(req_ready), 1);
    set_req(4, 7, 1, 0, 0, 0);
    #1 chk("R2 smem bound after return", int'(req_ready), 0);

    // R3 block 3 lives on sp0 slot2 and sp1 slot2
    finish(0, 2, 3);
    @(negedge clk);
    chk("R7 no done while warps remain", int'(done_valid), 0);
    finish(1, 2, 3);
    expect_done(3, "R3 block3");

    // Second phase: fill everything with one block
    do_reset();
    set_req(0, 0, 32, 100, 0, 1);
    #1 chk("R3 32-warp block fits", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    set_req(1, 0, 1, 0, 0, 0);
    #1 chk("R1 no slot left", int'(req_ready), 0);

    // free sp1 slot0 only; pointer still targets sp0
    finish(1, 0, 0);
    @(negedge clk);
    chk("R7 partial block no done", int'(done_valid), 0);
    #1 chk("R4 full target not skipped", int'(req_ready), 0);

    // R6 hold sp0 slot0 while instructions are in flight
    pend_cnt[0 +: PW] = 4'd3;
    finish(0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1 chk("R6 slot held while pending", int'(req_ready), 0);
    end
    // R8 drain and admit in the same cycle
    set_req(1, 0, 1, 0, 0, 1);
    pend_cnt[0 +: PW] = '0;
    #1 chk("R8 release counts for admission", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 block0 not complete", int'(done_valid), 0);

    // R3 new warp took sp0 slot0
    finish(0, 0, 1);
    expect_done(1, "R3 block1 on sp0 slot0");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule